// File: doc/BRIEF.md
# Frame-Pulse Synchronous Serial Master

This block is the master end of a synchronous serial link that marks each word with a one-period frame pulse rather than a held chip select. Software-side logic writes parallel words into a small transmit queue. The block turns each queued word into a serial frame of a programmed length, from 4 to 16 bits. It generates the serial clock from the system clock and drives an enable for an external line driver while it transmits. The word clocked in on the serial input during each frame goes into a receive queue, where it can be read as a parallel word.

When the next word is already queued at the moment the current word's last bit period begins, the frame pulse for that next word is issued during that last bit period. The serial clock then runs without a pause from the first word to the last. The word size and the clock divider are captured only when a transfer starts from idle. Changes made to them while a stream is running take effect at the next start from idle.

Top module: `fpsync_master`

## Requirements
- R1: After reset, `ser_clk`, `ser_frm`, `ser_txd`, `drv_oe`, `busy`, `tx_full` and `rx_valid` are all low.
- R2: `cfg_size` holds the word length minus one. Codes 3 to 15 give 4 to 16 bits, and codes below 3 give 4 bits. Each frame carries exactly that many data bits, most significant bit first. Bits of `tx_data` above the word length are not sent.
- R3: `ser_clk` stays low while no frame is in progress. During a transfer it has a period of 2·`cfg_half` system clocks (a `cfg_half` of 0 acts as 1). It spends the first `cfg_half` clocks of each period high, so every bit period begins with a rising edge.
- R4: `ser_frm` goes high at a rising edge of `ser_clk` and stays high for exactly one serial clock period. That period immediately precedes the period that carries the word's most significant bit.
- R5: `ser_txd` changes only at a rising edge of `ser_clk`, or when the block returns to idle. `ser_rxd` is captured at the falling edge in the middle of each data bit period.
- R6: A received word appears on `rx_data` right-justified, with its unused upper bits zero. `rx_valid` is high while the receive queue holds a word, and a cycle with `rx_rd` high removes the oldest word.
- R7: If the transmit queue is not empty when the last bit period of a word begins, then `ser_frm` pulses during that last bit period and the next word's most significant bit follows directly. A stream of k words of n bits therefore takes exactly k·n+1 serial clock periods.
- R8: `drv_oe` goes high with the first frame pulse and stays high until the end of the last bit period of the final word in a stream. `ser_frm` is never high while `drv_oe` is low.
- R9: `cfg_size` and `cfg_half` are sampled only when a transfer starts from idle. Changing them during a stream has no effect on that stream.
- R10: Each queue holds 8 words. `tx_full` is high while 8 words are waiting. A write to a full transmit queue is discarded, and a word received while the receive queue is full is discarded.
- R11: `busy` is high while a frame is in progress or a transmit word is waiting, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_size | input | 4 | Word length minus one (3..15) |
| cfg_half | input | 8 | System clocks per serial clock half period |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_data | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit queue holds 8 words |
| rx_rd | input | 1 | Remove the oldest received word |
| rx_data | output | 16 | Oldest received word, right-justified |
| rx_valid | output | 1 | Receive queue is not empty |
| busy | output | 1 | Frame in progress or word waiting |
| ser_clk | output | 1 | Serial clock, low when idle |
| ser_frm | output | 1 | One-period frame pulse |
| ser_txd | output | 1 | Serial transmit data |
| ser_rxd | input | 1 | Serial receive data |
| drv_oe | output | 1 | Enable for the external line driver |

## Verification
The bench connects a serial slave model that sends its own reply words and records the words it receives. Each test checks that the sent and received words are intact at the 4-, 8- and 16-bit sizes and at several divider settings. A design that shifted the wrong end first, or that sampled on the wrong edge, would corrupt these words. The bench counts serial clock rising edges across a three-word stream. A design that went idle between queued words, or that placed the next frame pulse after the least significant bit instead of during it, would produce a count other than k·n+1. A size and divider change made in the middle of a stream must leave the stream's word length and clock period unchanged. Ten quick writes against a slow clock overflow both queues; a design that overwrote a queue entry instead of discarding the new one would send or return the wrong words.

// File: rtl/fpsync_pkg.sv
// Shared definitions for the frame-pulse synchronous serial master.
// Assumes: nothing beyond the constants below.
package fpsync_pkg;

    // Shortest supported word, in bits.
    localparam int MIN_BITS = 4;

    // Phase of the transfer engine.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_DATA  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/fpsync_fifo.sv
// Synchronous first-word-fall-through queue.
// What it does: stores up to DEPTH words. The head word is always visible on
// rd_data, and a push while full or a pop while empty is ignored.
// Assumes: DEPTH is a power of two, so the pointers wrap by themselves.
module fpsync_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    fill;
    logic             do_push;
    logic             do_pop;

    // Decide which requests are taken this cycle.
    always_comb begin
        do_push = wr_en && !full;
        do_pop  = rd_en && !empty;
    end

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign rd_data = store[rptr];

    // Write the storage array; it holds no reset value.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wptr] <= wr_data;
        end
    end

    // Advance the pointers and the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_push) begin
                wptr <= wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/fpsync_divider.sv
// Half-period timer for the serial clock.
// What it does: while run is high, it raises tick once every (half_m1 + 1)
// system clocks, counting from the cycle in which run first goes high.
// Assumes: half_m1 is held constant while run is high.
module fpsync_divider #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_m1,
    output logic              tick
);
    logic [HALF_W-1:0] count;

    assign tick = run && (count == half_m1);

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run || tick) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/fpsync_engine.sv
// Frame engine for the frame-pulse synchronous serial format.
// What it does: takes words from the transmit queue and issues for each one a
// frame pulse period followed by the data bits, MSB first. It drives data on
// rising serial clock edges and samples on falling ones. When the queue still
// holds a word at the start of the last bit, the next frame pulse overlaps
// that last bit.
// Assumes: tick comes from a divider that is reloaded from half_m1 and gated
// by running.
module fpsync_engine
    import fpsync_pkg::*;
#(
    parameter int MAX_W  = 16,
    parameter int SZ_W   = 4,
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [MAX_W-1:0]  q_head,
    output logic              q_pop,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic              ser_rxd,
    output logic              ser_clk,
    output logic              ser_frm,
    output logic              ser_txd,
    output logic              drv_oe,
    output logic              running,
    output logic [HALF_W-1:0] half_m1,
    output logic              rx_push,
    output logic [MAX_W-1:0]  rx_word
);
    eng_state_e        state;
    logic [MAX_W-1:0]  tx_shift;
    logic [MAX_W-1:0]  rx_shift;
    logic [MAX_W-1:0]  next_word;
    logic              next_ready;
    logic [SZ_W-1:0]   bit_idx;
    logic [SZ_W-1:0]   size_q;
    logic [HALF_W-1:0] half_q;
    logic              rise_due;
    logic              fall_due;
    logic              chain_pop;
    logic              start_pop;

    // Force a size code into the supported range.
    function automatic logic [SZ_W-1:0] fit_size(input logic [SZ_W-1:0] s);
        if (int'(s) < MIN_BITS - 1) begin
            return SZ_W'(MIN_BITS - 1);
        end
        if (int'(s) > MAX_W - 1) begin
            return SZ_W'(MAX_W - 1);
        end
        return s;
    endfunction

    // Move the word's MSB to the top of the shifter; unused high bits drop out.
    function automatic logic [MAX_W-1:0] left_align(input logic [MAX_W-1:0] w,
                                                    input logic [SZ_W-1:0]  s);
        return w << (MAX_W - 1 - int'(s));
    endfunction

    // Turn a half-period request into a nonzero count.
    function automatic logic [HALF_W-1:0] fit_half(input logic [HALF_W-1:0] h);
        return (h == '0) ? HALF_W'(1) : h;
    endfunction

    // Find the edge events and the queue pops for this cycle.
    always_comb begin
        rise_due  = tick && !ser_clk;
        fall_due  = tick && ser_clk;
        start_pop = (state == ST_IDLE) && !q_empty;
        chain_pop = (state == ST_DATA) && rise_due && (bit_idx == SZ_W'(1)) && !q_empty;
        q_pop     = start_pop || chain_pop;
        rx_push   = (state == ST_DATA) && fall_due && (bit_idx == '0);
        rx_word   = {rx_shift[MAX_W-2:0], ser_rxd};
    end

    assign running = (state != ST_IDLE);
    assign half_m1 = half_q - 1'b1;

    // Sequence the frame pulse, the data bits and the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ser_clk    <= 1'b0;
            ser_frm    <= 1'b0;
            ser_txd    <= 1'b0;
            drv_oe     <= 1'b0;
            tx_shift   <= '0;
            rx_shift   <= '0;
            next_word  <= '0;
            next_ready <= 1'b0;
            bit_idx    <= '0;
            size_q     <= SZ_W'(MIN_BITS - 1);
            half_q     <= HALF_W'(1);
        end else begin
            case (state)
                ST_IDLE: begin
                    if (!q_empty) begin
                        size_q   <= fit_size(cfg_size);
                        half_q   <= fit_half(cfg_half);
                        tx_shift <= left_align(q_head, fit_size(cfg_size));
                        state    <= ST_PULSE;
                        ser_clk  <= 1'b1;
                        ser_frm  <= 1'b1;
                        ser_txd  <= 1'b0;
                        drv_oe   <= 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (fall_due) begin
                        ser_clk <= 1'b0;
                    end else if (rise_due) begin
                        ser_clk  <= 1'b1;
                        ser_frm  <= 1'b0;
                        ser_txd  <= tx_shift[MAX_W-1];
                        tx_shift <= tx_shift << 1;
                        bit_idx  <= size_q;
                        rx_shift <= '0;
                        state    <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (fall_due) begin
                        ser_clk  <= 1'b0;
                        rx_shift <= {rx_shift[MAX_W-2:0], ser_rxd};
                    end else if (rise_due) begin
                        if (bit_idx != '0) begin
                            ser_clk  <= 1'b1;
                            ser_txd  <= tx_shift[MAX_W-1];
                            tx_shift <= tx_shift << 1;
                            bit_idx  <= bit_idx - 1'b1;
                            if (chain_pop) begin
                                ser_frm    <= 1'b1;
                                next_word  <= left_align(q_head, size_q);
                                next_ready <= 1'b1;
                            end
                        end else if (next_ready) begin
                            ser_clk    <= 1'b1;
                            ser_frm    <= 1'b0;
                            ser_txd    <= next_word[MAX_W-1];
                            tx_shift   <= next_word << 1;
                            bit_idx    <= size_q;
                            rx_shift   <= '0;
                            next_ready <= 1'b0;
                        end else begin
                            ser_clk <= 1'b0;
                            ser_frm <= 1'b0;
                            ser_txd <= 1'b0;
                            drv_oe  <= 1'b0;
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/fpsync_master.sv
// Frame-pulse synchronous serial master, top level.
// What it does: it places a transmit queue and a receive queue around the
// frame engine and the serial clock divider, and reports busy while work is
// waiting or a frame is in progress.
// Assumes: QDEPTH is a power of two, and ser_rxd is synchronous to the serial
// clock this block generates.
module fpsync_master #(
    parameter int MAX_W  = 16,
    parameter int QDEPTH = 8,
    parameter int HALF_W = 8,
    localparam int SZ_W  = $clog2(MAX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic              tx_wr,
    input  logic [MAX_W-1:0]  tx_data,
    output logic              tx_full,
    input  logic              rx_rd,
    output logic [MAX_W-1:0]  rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              ser_clk,
    output logic              ser_frm,
    output logic              ser_txd,
    input  logic              ser_rxd,
    output logic              drv_oe
);
    logic              txq_empty;
    logic [MAX_W-1:0]  txq_head;
    logic              txq_pop;
    logic              rxq_empty;
    logic              rxq_full;
    logic              rx_push;
    logic [MAX_W-1:0]  rx_word;
    logic              tick;
    logic              running;
    logic [HALF_W-1:0] half_m1;

    // Transmit queue: parallel words waiting to be sent.
    fpsync_fifo #(.WIDTH(MAX_W), .DEPTH(QDEPTH)) i_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tx_wr),
        .wr_data (tx_data),
        .rd_en   (txq_pop),
        .rd_data (txq_head),
        .full    (tx_full),
        .empty   (txq_empty)
    );

    // Receive queue: words captured from the serial input.
    fpsync_fifo #(.WIDTH(MAX_W), .DEPTH(QDEPTH)) i_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rx_push),
        .wr_data (rx_word),
        .rd_en   (rx_rd),
        .rd_data (rx_data),
        .full    (rxq_full),
        .empty   (rxq_empty)
    );

    // Serial clock half-period timer.
    fpsync_divider #(.HALF_W(HALF_W)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .half_m1 (half_m1),
        .tick    (tick)
    );

    // Frame sequencing and shifting.
    fpsync_engine #(.MAX_W(MAX_W), .SZ_W(SZ_W), .HALF_W(HALF_W)) i_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .q_empty  (txq_empty),
        .q_head   (txq_head),
        .q_pop    (txq_pop),
        .cfg_size (cfg_size),
        .cfg_half (cfg_half),
        .ser_rxd  (ser_rxd),
        .ser_clk  (ser_clk),
        .ser_frm  (ser_frm),
        .ser_txd  (ser_txd),
        .drv_oe   (drv_oe),
        .running  (running),
        .half_m1  (half_m1),
        .rx_push  (rx_push),
        .rx_word  (rx_word)
    );

    assign rx_valid = !rxq_empty;
    assign busy     = running || !txq_empty;

endmodule

// File: rtl/fpsync_master_chk.sv
// Property checker for fpsync_master, attached through bind.
// What it does: checks the relations among the serial pins and busy over
// time.
// Assumes: it observes only ports of the top module.
module fpsync_master_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_clk,
    input logic ser_frm,
    input logic ser_txd,
    input logic drv_oe,
    input logic busy
);
    // R3: the serial clock rests low when the driver is off.
    p_clk_rests_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_oe |-> !ser_clk);

    // R3: every rising serial clock edge belongs to an enabled transfer.
    p_rise_inside_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> drv_oe);

    // R4: the frame signal changes only at a rising serial clock edge.
    p_frm_moves_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_frm) |-> $rose(ser_clk));

    // R5: transmit data moves only at a rising edge or on the return to idle.
    p_txd_moves_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_txd) |-> ($rose(ser_clk) || $fell(drv_oe)));

    // R8: no frame pulse without the line driver enabled.
    p_frm_within_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frm |-> drv_oe);

    // R11: an idle port has the driver switched off.
    p_idle_driver_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drv_oe);

endmodule

bind fpsync_master fpsync_master_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_clk (ser_clk),
    .ser_frm (ser_frm),
    .ser_txd (ser_txd),
    .drv_oe  (drv_oe),
    .busy    (busy)
);

// File: tb/test_fpsync_master.sv
// Directed bench for fpsync_master. A serial slave model answers every frame
// and a pin monitor measures the timing; each task checks its own scenario.
module test_fpsync_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_size = 4'd7;
    logic [7:0]  cfg_half = 8'd2;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_full;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        busy;
    logic        ser_clk;
    logic        ser_frm;
    logic        ser_txd;
    logic        ser_rxd;
    logic        drv_oe;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    fpsync_master i_fpsync_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_size (cfg_size),
        .cfg_half (cfg_half),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .tx_full  (tx_full),
        .rx_rd    (rx_rd),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .busy     (busy),
        .ser_clk  (ser_clk),
        .ser_frm  (ser_frm),
        .ser_txd  (ser_txd),
        .ser_rxd  (ser_rxd),
        .drv_oe   (drv_oe)
    );

    // Expectations set by the tests and read by the monitor and slave.
    int          exp_h = 2;
    int          sl_n  = 8;
    logic [15:0] rep [32];
    logic [15:0] slw [32];

    // Monitor and slave state; only the negedge process writes these.
    int   cyc = 0;
    int   rises = 0, pulses = 0, oe_falls = 0;
    int   per_err = 0, hi_err = 0, frm_err = 0, txd_err = 0, idle_err = 0;
    int   last_rise = 0, frm_start = 0;
    bit   have_rise = 1'b0;
    logic p_clk = 1'b0, p_frm = 1'b0, p_txd = 1'b0, p_oe = 1'b0;
    bit   sl_pend = 1'b0, sl_act = 1'b0;
    int   sl_pos = 0, sl_starts = 0, sl_cnt = 0;
    logic [15:0] sl_cur = '0, sl_rep = '0;
    logic        rxd_q = 1'b0;

    assign ser_rxd = rxd_q;

    // Pin timing monitor plus slave: answers rises and samples on falls.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ser_clk && !p_clk) begin
                rises++;
                if (have_rise && (cyc - last_rise) != 2 * exp_h) per_err++;
                last_rise = cyc;
                have_rise = 1'b1;
                if (sl_pend) begin
                    sl_pend = 1'b0;
                    sl_act  = 1'b1;
                    sl_pos  = sl_n - 1;
                    sl_rep  = rep[sl_starts % 32];
                    sl_cur  = '0;
                    sl_starts++;
                end else if (sl_act) begin
                    if (sl_pos == 0) sl_act = 1'b0;
                    else sl_pos--;
                end
                rxd_q = sl_act ? sl_rep[sl_pos] : 1'b0;
                if (ser_frm) sl_pend = 1'b1;
            end
            if (!ser_clk && p_clk) begin
                if ((cyc - last_rise) != exp_h) hi_err++;
                if (sl_act) begin
                    sl_cur[sl_pos] = ser_txd;
                    if (sl_pos == 0) begin
                        slw[sl_cnt % 32] = sl_cur;
                        sl_cnt++;
                    end
                end
            end
            if (ser_frm && !p_frm) begin
                pulses++;
                frm_start = cyc;
                if (!(ser_clk && !p_clk)) frm_err++;
            end
            if (!ser_frm && p_frm && (cyc - frm_start) != 2 * exp_h) frm_err++;
            if (ser_txd != p_txd && !(ser_clk && !p_clk) && !(!drv_oe && p_oe)) txd_err++;
            if (ser_clk && !drv_oe) idle_err++;
            if (!drv_oe && p_oe) begin
                oe_falls++;
                have_rise = 1'b0;
            end
        end
        p_clk = ser_clk;
        p_frm = ser_frm;
        p_txd = ser_txd;
        p_oe  = drv_oe;
    end

    task automatic check(input int act, input int exp, input string req, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] w);
        tx_data = w;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic pop_check(input logic [15:0] exp, input string req);
        check(int'(rx_valid), 1, req, "rx_valid before read");
        check(int'(rx_data), int'(exp), req, "rx_data");
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((busy || drv_oe) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    // R1: quiet pins and empty queues after reset.
    task automatic t_reset();
        check(int'({ser_clk, ser_frm, ser_txd, drv_oe}), 0, "R1", "serial pins after reset");
        check(int'({busy, tx_full, rx_valid}), 0, "R1", "flags after reset");
    endtask

    // R2 R3 R4 R5 R6 R8 R11: one word at a given size and divider.
    task automatic t_single(input int bits, input int half, input logic [15:0] w,
                            input logic [15:0] reply);
        int r0, p0, f0, e0, s0;
        logic [15:0] mask;
        mask = 16'((32'd1 << bits) - 1);
        cfg_size = 4'(bits - 1);
        cfg_half = 8'(half);
        exp_h = half;
        sl_n = bits;
        rep[sl_starts % 32] = reply;
        r0 = rises; p0 = pulses; f0 = oe_falls; s0 = sl_cnt;
        e0 = per_err + hi_err + frm_err + txd_err + idle_err;
        write_word(w);
        check(int'(busy), 1, "R11", "busy with word queued");
        wait_idle();
        check(int'(slw[s0 % 32]), int'(w & mask), "R2", "word seen by slave, MSB first");
        check(sl_cnt - s0, 1, "R2", "frames completed");
        check(rises - r0, bits + 1, "R3", "serial clock periods for one frame");
        check(pulses - p0, 1, "R4", "frame pulses");
        check(per_err + hi_err + frm_err + txd_err + idle_err - e0, 0, "R5",
              "clock/pulse/data edge violations");
        check(oe_falls - f0, 1, "R8", "driver enable windows");
        check(int'({ser_clk, busy, drv_oe}), 0, "R3", "pins idle after frame");
        pop_check(reply & mask, "R6");
        check(int'(rx_valid), 0, "R6", "receive queue drained");
    endtask

    // R7: three queued words run as one unbroken stream.
    task automatic t_stream();
        int r0, p0, f0, s0, e0;
        cfg_size = 4'd11;
        cfg_half = 8'd2;
        exp_h = 2;
        sl_n = 12;
        rep[sl_starts % 32]       = 16'h0ABC;
        rep[(sl_starts + 1) % 32] = 16'h0123;
        rep[(sl_starts + 2) % 32] = 16'h0F0F;
        r0 = rises; p0 = pulses; f0 = oe_falls; s0 = sl_cnt;
        e0 = per_err + frm_err + txd_err;
        write_word(16'h0C35);
        write_word(16'h0A5A);
        write_word(16'h0777);
        wait_idle();
        check(rises - r0, 3 * 12 + 1, "R7", "periods in 3-word stream");
        check(pulses - p0, 3, "R7", "frame pulses in stream");
        check(oe_falls - f0, 1, "R8", "single enable window for stream");
        check(per_err + frm_err + txd_err - e0, 0, "R7", "stream timing violations");
        check(int'(slw[s0 % 32]), 16'h0C35, "R7", "stream word 0");
        check(int'(slw[(s0 + 1) % 32]), 16'h0A5A, "R7", "stream word 1");
        check(int'(slw[(s0 + 2) % 32]), 16'h0777, "R7", "stream word 2");
        pop_check(16'h0ABC, "R7");
        pop_check(16'h0123, "R7");
        pop_check(16'h0F0F, "R7");
    endtask

    // R9: configuration changed in the middle of a stream is not used.
    task automatic t_cfg_hold();
        int s0, e0;
        cfg_size = 4'd15;
        cfg_half = 8'd2;
        exp_h = 2;
        sl_n = 16;
        rep[sl_starts % 32]       = 16'hBEEF;
        rep[(sl_starts + 1) % 32] = 16'h1234;
        s0 = sl_cnt;
        e0 = per_err + hi_err;
        write_word(16'hC0DE);
        write_word(16'h8001);
        repeat (6) @(negedge clk);
        cfg_size = 4'd3;
        cfg_half = 8'd5;
        wait_idle();
        check(per_err + hi_err - e0, 0, "R9", "clock period held during stream");
        check(sl_cnt - s0, 2, "R9", "frames at held size");
        check(int'(slw[s0 % 32]), 16'hC0DE, "R9", "first word at 16 bits");
        check(int'(slw[(s0 + 1) % 32]), 16'h8001, "R9", "second word at 16 bits");
        pop_check(16'hBEEF, "R9");
        pop_check(16'h1234, "R9");
    endtask

    // R10: ten fast writes against a slow clock overflow both queues.
    task automatic t_overflow();
        int s0;
        cfg_size = 4'd3;
        cfg_half = 8'd20;
        exp_h = 20;
        sl_n = 4;
        s0 = sl_cnt;
        for (int i = 0; i < 10; i++) rep[(sl_starts + i) % 32] = 16'(15 - i);
        for (int i = 0; i < 10; i++) begin
            tx_data = 16'(i + 1);
            tx_wr   = 1'b1;
            @(negedge clk);
        end
        tx_wr = 1'b0;
        check(int'(tx_full), 1, "R10", "tx_full with 8 words waiting");
        wait_idle();
        check(sl_cnt - s0, 9, "R10", "words sent (tenth dropped)");
        check(int'(slw[(s0 + 8) % 32]), 9, "R10", "last word sent");
        for (int i = 0; i < 8; i++) pop_check(16'(15 - i), "R10");
        check(int'(rx_valid), 0, "R10", "ninth received word dropped");
    endtask

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single(8, 2, 16'hFFA5, 16'h003C);
        t_single(4, 1, 16'h0009, 16'hFFF6);
        t_single(16, 3, 16'hB38D, 16'h5AC3);
        t_stream();
        t_cfg_hold();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule